// File: doc/BRIEF.md
# DMA Address and Byte-Count Engine with Queued Next Transfer

This block keeps the live address and remaining byte count of a DMA channel, together with a queued address and count for the transfer that follows. Each accepted transfer beat counts the remaining bytes down by one and steps the address up by one. When the count runs out, the block can switch to the queued transfer in the same cycle, so two transfers run back to back with no software gap.

Software programs the block through a simple write port. A level input selects the queued mode. While that input is low, address and count writes land in the live registers. While it is high, the same writes fill the hidden queued registers. If the count runs out in queued mode and no new queued address has arrived since the last switch, the channel parks. It ignores transfer beats and reports itself off until software writes a queued address. The queued values are then copied into the live registers before any beat is accepted. A parameter selects how the address steps: across the full width, or inside a window where only the low bits count and the upper bits stay fixed.

The datapath drives one beat strobe per byte. It watches the terminal-count pulse and the DMA-on status to decide when to request more data. Bus protocol and data movement belong to neighbouring blocks.

Top module: `dma_autoload_regs`

## Requirements
- R1: After reset, the live address and the count are 0. The loaded flag (`aload_o`), the queued flag (`naload_o`), `tc_o` and `dma_on_o` are all 0.
- R2: With `nxt_en_i` low, an address write loads `wr_data_i` into the live address and sets `aload_o` on the next clock. A count write loads only the low CNT_W (24) bits of `wr_data_i` into the live count.
- R3: A beat (`xfer_i` high) is accepted only when `aload_o`=1, `dma_en_i`=1, `err_i`=0 and the count is not zero. An accepted beat lowers the count by 1 and advances the address by 1 on the next clock. Any other beat leaves the address and the count unchanged.
- R4: `tc_o` is high for exactly the one cycle after an accepted beat takes the count from 1 to 0.
- R5: With `nxt_en_i` high, an address write goes to the queued address and sets `naload_o`, and a count write goes to the queued count. The live address and the live count stay unchanged.
- R6: At expiry with `nxt_en_i`=1 and `naload_o`=1, the queued address and the queued count are copied into the live registers in the same clock. `naload_o` clears, and `aload_o` stays 1.
- R7: At expiry with `nxt_en_i`=1 and `naload_o`=0, `aload_o` clears and `dma_on_o` reads 0. Beats are then ignored.
- R8: When `aload_o`=0, `nxt_en_i`=1 and a queued address has been written, the next clock copies both queued registers into the live ones, sets `aload_o` and clears `naload_o`. No beat is accepted before that copy.
- R9: `dma_on_o` = (`aload_o` OR `naload_o`) AND `dma_en_i` AND NOT `err_i`.
- R10: At expiry with `nxt_en_i`=0, `aload_o` clears and the count stays at 0 until software writes again.
- R11: With ADDR_MODE=1 (window mode), only the low WIN_W bits of the address step and wrap to 0, and the upper bits hold. With ADDR_MODE=0, the carry runs across the full address width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_addr_i | input | 1 | Address register write strobe |
| wr_cnt_i | input | 1 | Count register write strobe |
| wr_data_i | input | ADDR_W | Write data |
| nxt_en_i | input | 1 | Queued-transfer mode enable (level) |
| dma_en_i | input | 1 | DMA enable (level) |
| err_i | input | 1 | Error pending (level) |
| xfer_i | input | 1 | Transfer beat from datapath |
| cur_addr_o | output | ADDR_W | Live address |
| cur_cnt_o | output | CNT_W | Live remaining count |
| tc_o | output | 1 | Terminal-count pulse |
| dma_on_o | output | 1 | DMA-on status |
| aload_o | output | 1 | Live address holds a valid value |
| naload_o | output | 1 | Queued address written and not yet used |

## Verification
The assertions check on every cycle that a pulse on `tc_o` always follows a beat seen at a count of one. They also check that a queued switch at expiry leaves the loaded flag set and the live address equal to the old queued address, and that an expiry with nothing queued parks the channel. Further per-cycle checks cover three points: the queued flag rises only from a queued address write, the live count does not move while the channel is unloaded, and direct address writes land as written. Only the bench scenarios can show whole sequences. These are a full back-to-back switch with exact addresses and counts, a park followed by a restart with beats held high, beats blocked by the error and enable inputs, the upper count bits being dropped, and the difference between the window and full-width address modes.

// File: rtl/dma_al_pkg.sv
package dma_al_pkg;
   localparam int unsigned MODE_FULL   = 0;
   localparam int unsigned MODE_WINDOW = 1;

   typedef struct packed {
      logic accept;   // beat taken this cycle
      logic expire;   // beat takes count 1 -> 0
      logic reload;   // expiry with queued values present
      logic promote;  // parked channel restarted from queue
      logic consume;  // queued values copied this cycle
      logic park;     // expiry with nothing to switch to
   } dma_al_evt_t;
endpackage

// File: rtl/dma_al_ctrl.sv
module dma_al_ctrl
   import dma_al_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             xfer_i,
   input  logic             dma_en_i,
   input  logic             err_i,
   input  logic             nxt_en_i,
   input  logic             aload_q,
   input  logic             naload_q,
   input  logic [CNT_W-1:0] cnt_q,
   output dma_al_evt_t      evt_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic cnt_live;
   assign cnt_live = |cnt_q;

   always_comb begin
      evt_o         = '0;
      evt_o.accept  = xfer_i & aload_q & dma_en_i & ~err_i & cnt_live;
      evt_o.expire  = evt_o.accept & (cnt_q == CNT_ONE);
      evt_o.reload  = evt_o.expire & nxt_en_i & naload_q;
      evt_o.promote = ~aload_q & nxt_en_i & naload_q;
      evt_o.consume = evt_o.reload | evt_o.promote;
      evt_o.park    = evt_o.expire & ~evt_o.reload;
   end
endmodule

// File: rtl/dma_al_shadow.sv
module dma_al_shadow #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_addr_i,
   input  logic              wr_cnt_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic              nxt_en_i,
   input  logic              consume_i,
   output logic [ADDR_W-1:0] nxt_addr_o,
   output logic [CNT_W-1:0]  nxt_cnt_o,
   output logic              naload_o
);
   logic q_addr_wr, q_cnt_wr;
   assign q_addr_wr = wr_addr_i & nxt_en_i;
   assign q_cnt_wr  = wr_cnt_i & nxt_en_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         nxt_addr_o <= '0;
         nxt_cnt_o  <= '0;
         naload_o   <= 1'b0;
      end else begin
         if (q_addr_wr) nxt_addr_o <= wr_data_i;
         if (q_cnt_wr)  nxt_cnt_o  <= wr_data_i[CNT_W-1:0];
         // a fresh write wins over consumption of the previous value
         if (q_addr_wr)      naload_o <= 1'b1;
         else if (consume_i) naload_o <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_al_addr_step.sv
module dma_al_addr_step
   import dma_al_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned ADDR_MODE = MODE_FULL,
   parameter int unsigned WIN_W     = 24
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   generate
      if (ADDR_MODE == MODE_WINDOW && WIN_W < ADDR_W) begin : g_window
         logic [WIN_W-1:0] low_next;
         assign low_next = addr_i[WIN_W-1:0] + WIN_W'(1);
         assign addr_o   = {addr_i[ADDR_W-1:WIN_W], low_next};
      end else begin : g_full
         assign addr_o = addr_i + ADDR_W'(1);
      end
   endgenerate
endmodule

// File: rtl/dma_autoload_regs.sv
module dma_autoload_regs
   import dma_al_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned CNT_W     = 24,
   parameter int unsigned ADDR_MODE = MODE_FULL,
   parameter int unsigned WIN_W     = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_addr_i,
   input  logic              wr_cnt_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic              nxt_en_i,
   input  logic              dma_en_i,
   input  logic              err_i,
   input  logic              xfer_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [CNT_W-1:0]  cur_cnt_o,
   output logic              tc_o,
   output logic              dma_on_o,
   output logic              aload_o,
   output logic              naload_o
);
   initial begin
      assert (CNT_W >= 2 && CNT_W <= ADDR_W)
         else $error("dma_autoload_regs: CNT_W must be in 2..ADDR_W");
      assert (ADDR_MODE == MODE_FULL || ADDR_MODE == MODE_WINDOW)
         else $error("dma_autoload_regs: unknown ADDR_MODE");
      assert (ADDR_MODE != MODE_WINDOW || (WIN_W >= 1 && WIN_W < ADDR_W))
         else $error("dma_autoload_regs: WIN_W must be below ADDR_W");
   end

   dma_al_evt_t       evt;
   logic [ADDR_W-1:0] nxt_addr_q;
   logic [CNT_W-1:0]  nxt_cnt_q;
   logic [ADDR_W-1:0] addr_q, addr_step;
   logic [CNT_W-1:0]  cnt_q;
   logic              aload_q, naload_q, tc_q;
   logic              direct_addr_wr, direct_cnt_wr;

   assign direct_addr_wr = wr_addr_i & ~nxt_en_i;
   assign direct_cnt_wr  = wr_cnt_i & ~nxt_en_i;

   dma_al_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .xfer_i   (xfer_i),
      .dma_en_i (dma_en_i),
      .err_i    (err_i),
      .nxt_en_i (nxt_en_i),
      .aload_q  (aload_q),
      .naload_q (naload_q),
      .cnt_q    (cnt_q),
      .evt_o    (evt)
   );

   dma_al_shadow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shadow (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_addr_i  (wr_addr_i),
      .wr_cnt_i   (wr_cnt_i),
      .wr_data_i  (wr_data_i),
      .nxt_en_i   (nxt_en_i),
      .consume_i  (evt.consume),
      .nxt_addr_o (nxt_addr_q),
      .nxt_cnt_o  (nxt_cnt_q),
      .naload_o   (naload_q)
   );

   dma_al_addr_step #(.ADDR_W(ADDR_W), .ADDR_MODE(ADDR_MODE), .WIN_W(WIN_W)) u_step (
      .addr_i (addr_q),
      .addr_o (addr_step)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q  <= '0;
         cnt_q   <= '0;
         aload_q <= 1'b0;
         tc_q    <= 1'b0;
      end else begin
         tc_q <= evt.expire;

         if (direct_addr_wr)   addr_q <= wr_data_i;
         else if (evt.consume) addr_q <= nxt_addr_q;
         else if (evt.accept)  addr_q <= addr_step;

         if (direct_cnt_wr)    cnt_q <= wr_data_i[CNT_W-1:0];
         else if (evt.consume) cnt_q <= nxt_cnt_q;
         else if (evt.accept)  cnt_q <= cnt_q - CNT_W'(1);

         if (direct_addr_wr || evt.consume) aload_q <= 1'b1;
         else if (evt.park)                 aload_q <= 1'b0;
      end
   end

   assign cur_addr_o = addr_q;
   assign cur_cnt_o  = cnt_q;
   assign tc_o       = tc_q;
   assign aload_o    = aload_q;
   assign naload_o   = naload_q;
   assign dma_on_o   = (aload_q | naload_q) & dma_en_i & ~err_i;
endmodule

// File: rtl/dma_al_checker.sv
module dma_al_checker #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_addr_i,
   input logic              wr_cnt_i,
   input logic [ADDR_W-1:0] wr_data_i,
   input logic              nxt_en_i,
   input logic              xfer_i,
   input logic [ADDR_W-1:0] cur_addr_o,
   input logic [CNT_W-1:0]  cur_cnt_o,
   input logic              tc_o,
   input logic              dma_on_o,
   input logic              aload_o,
   input logic              naload_o,
   input logic [ADDR_W-1:0] nxt_addr_q
);
   assert_direct_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_addr_i && !nxt_en_i) |=> (aload_o && cur_addr_o == $past(wr_data_i)));

   assert_tc_after_last_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o |-> ($past(xfer_i) && $past(cur_cnt_o) == CNT_W'(1) && cur_cnt_o != $past(cur_cnt_o)));

   assert_queue_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(naload_o) |-> ($past(wr_addr_i) && $past(nxt_en_i)));

   assert_switch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_o && $past(nxt_en_i) && $past(naload_o))
         |-> (aload_o && cur_addr_o == $past(nxt_addr_q) && naload_o == $past(wr_addr_i)));

   assert_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_o && $past(nxt_en_i) && !$past(naload_o) && !$past(wr_addr_i))
         |-> (!aload_o && !dma_on_o));

   assert_no_beat_unloaded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!aload_o && !wr_cnt_i && !(nxt_en_i && naload_o)) |=> $stable(cur_cnt_o));
endmodule

bind dma_autoload_regs dma_al_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_addr_i  (wr_addr_i),
   .wr_cnt_i   (wr_cnt_i),
   .wr_data_i  (wr_data_i),
   .nxt_en_i   (nxt_en_i),
   .xfer_i     (xfer_i),
   .cur_addr_o (cur_addr_o),
   .cur_cnt_o  (cur_cnt_o),
   .tc_o       (tc_o),
   .dma_on_o   (dma_on_o),
   .aload_o    (aload_o),
   .naload_o   (naload_o),
   .nxt_addr_q (nxt_addr_q)
);

// File: tb/tb_dma_autoload_regs.sv
module tb_dma_autoload_regs;
   localparam time CLK_PERIOD = 10ns;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned CNT_W  = 24;

   logic              clk = 1'b0;
   logic              rst_ni = 1'b0;
   logic              wr_addr_i = 1'b0, wr_cnt_i = 1'b0;
   logic [ADDR_W-1:0] wr_data_i = '0;
   logic              nxt_en_i = 1'b0, dma_en_i = 1'b0, err_i = 1'b0, xfer_i = 1'b0;
   logic [ADDR_W-1:0] cur_addr, win_addr;
   logic [CNT_W-1:0]  cur_cnt, win_cnt;
   logic              tc, dma_on, aload, naload;
   logic              w_tc, w_dma_on, w_aload, w_naload;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_autoload_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_MODE(0), .WIN_W(24)) dut (
      .clk_i(clk), .rst_ni(rst_ni), .wr_addr_i(wr_addr_i), .wr_cnt_i(wr_cnt_i),
      .wr_data_i(wr_data_i), .nxt_en_i(nxt_en_i), .dma_en_i(dma_en_i), .err_i(err_i),
      .xfer_i(xfer_i), .cur_addr_o(cur_addr), .cur_cnt_o(cur_cnt), .tc_o(tc),
      .dma_on_o(dma_on), .aload_o(aload), .naload_o(naload)
   );

   dma_autoload_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_MODE(1), .WIN_W(24)) dut_win (
      .clk_i(clk), .rst_ni(rst_ni), .wr_addr_i(wr_addr_i), .wr_cnt_i(wr_cnt_i),
      .wr_data_i(wr_data_i), .nxt_en_i(nxt_en_i), .dma_en_i(dma_en_i), .err_i(err_i),
      .xfer_i(xfer_i), .cur_addr_o(win_addr), .cur_cnt_o(win_cnt), .tc_o(w_tc),
      .dma_on_o(w_dma_on), .aload_o(w_aload), .naload_o(w_naload)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // inputs change at a falling edge; one rising edge later, the next falling edge samples
   task automatic tick(); @(negedge clk); endtask

   task automatic write_addr(input logic [31:0] v);
      wr_addr_i = 1'b1; wr_data_i = v; tick(); wr_addr_i = 1'b0;
   endtask

   task automatic write_cnt(input logic [31:0] v);
      wr_cnt_i = 1'b1; wr_data_i = v; tick(); wr_cnt_i = 1'b0;
   endtask

   task automatic beats(input int n);
      xfer_i = 1'b1;
      for (int i = 0; i < n; i++) tick();
      xfer_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 addr", cur_addr, 0);
      chk("R1 cnt", 32'(cur_cnt), 0);
      chk("R1 flags", {28'd0, tc, dma_on, aload, naload}, 0);
   endtask

   task automatic t_direct();
      nxt_en_i = 1'b0; dma_en_i = 1'b1;
      write_addr(32'h0000_1000);
      write_cnt(32'hAB00_0003);
      chk("R2 addr", cur_addr, 32'h1000);
      chk("R2 cnt low bits only", 32'(cur_cnt), 3);
      chk("R2 aload", 32'(aload), 1);
      chk("R9 dma_on loaded", 32'(dma_on), 1);
      beats(2);
      chk("R3 addr step", cur_addr, 32'h1002);
      chk("R3 cnt down", 32'(cur_cnt), 1);
      chk("R4 no tc yet", 32'(tc), 0);
      beats(1);
      chk("R4 tc pulse", 32'(tc), 1);
      chk("R10 cnt zero", 32'(cur_cnt), 0);
      chk("R10 aload cleared", 32'(aload), 0);
      tick();
      chk("R4 tc one cycle", 32'(tc), 0);
      beats(3);
      chk("R10 addr held", cur_addr, 32'h1003);
      chk("R10 cnt held", 32'(cur_cnt), 0);
   endtask

   task automatic t_blocked();
      write_addr(32'h0000_2000);
      write_cnt(32'd5);
      err_i = 1'b1;
      #1 chk("R9 dma_on off on error", 32'(dma_on), 0);
      beats(2);
      chk("R3 error blocks beats", 32'(cur_cnt), 5);
      err_i = 1'b0; dma_en_i = 1'b0;
      #1 chk("R9 dma_on off when disabled", 32'(dma_on), 0);
      beats(2);
      chk("R3 disable blocks beats", cur_addr, 32'h2000);
      dma_en_i = 1'b1;
      #1 chk("R9 dma_on back", 32'(dma_on), 1);
   endtask

   task automatic t_switch();
      nxt_en_i = 1'b0;
      write_addr(32'h0000_3000);
      write_cnt(32'd2);
      nxt_en_i = 1'b1;
      write_cnt(32'd4);
      chk("R5 live cnt kept", 32'(cur_cnt), 2);
      write_addr(32'h0000_8000);
      chk("R5 live addr kept", cur_addr, 32'h3000);
      chk("R5 naload set", 32'(naload), 1);
      beats(2);
      chk("R6 tc at switch", 32'(tc), 1);
      chk("R6 addr switched", cur_addr, 32'h8000);
      chk("R6 cnt switched", 32'(cur_cnt), 4);
      chk("R6 flags", {30'd0, aload, naload}, 32'b10);
   endtask

   task automatic t_park_restart();
      beats(4);
      chk("R7 tc at park", 32'(tc), 1);
      chk("R7 aload cleared", 32'(aload), 0);
      chk("R7 dma_on off", 32'(dma_on), 0);
      beats(2);
      chk("R7 beats ignored", cur_addr, 32'h8004);
      xfer_i = 1'b1;
      write_cnt(32'd2);
      write_addr(32'h0000_9000);
      chk("R8 queued seen", 32'(naload), 1);
      chk("R8 live addr before copy", cur_addr, 32'h8004);
      tick();
      chk("R8 copied addr", cur_addr, 32'h9000);
      chk("R8 no beat before copy", 32'(cur_cnt), 2);
      chk("R8 flags", {30'd0, aload, naload}, 32'b10);
      tick();
      xfer_i = 1'b0;
      chk("R8 beat after copy", cur_addr, 32'h9001);
   endtask

   task automatic t_window();
      nxt_en_i = 1'b0;
      write_addr(32'h12FF_FFFE);
      write_cnt(32'd4);
      beats(2);
      chk("R11 full carry", cur_addr, 32'h1300_0000);
      chk("R11 window wrap", win_addr, 32'h1200_0000);
      chk("R11 window cnt", 32'(win_cnt), 2);
   endtask

   initial begin
      repeat (3) tick();
      rst_ni = 1'b1;
      tick();
      t_reset();
      t_direct();
      t_blocked();
      t_switch();
      t_park_restart();
      t_window();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule